// File: doc/BRIEF.md
# Condition Code Evaluator for Byte-Set and Conditional Move

This block turns a 4-bit condition selector and the four arithmetic flags (carry, zero, sign, overflow) into a single true or false outcome. Two small datapaths use that outcome. The byte-set path writes 0 or 1 into the low byte of a destination and passes the other bytes through unchanged. The conditional-move path either replaces a 16-, 32- or 64-bit destination with its source or keeps it.

The block is purely combinational and has no clock and no state. An execution stage places it behind its flag register. The stage drives the selector, the flags, the operands and the move width. It takes the results back in the same cycle. Selector codes with no defined condition return false and raise a flag. A move request of byte width is refused and flagged.

Top module: `cc_select_unit`

## Requirements
- R1: Selector 1 (equal) is true exactly when ZF is 1. Selector 2 (not equal) is true exactly when ZF is 0.
- R2: Selector 3 (negative) is true exactly when SF is 1. Selector 4 (nonnegative) is true exactly when SF is 0.
- R3: Signed relations are evaluated as follows. Selector 5 (greater) is !(SF^OF) && !ZF. Selector 6 (greater or equal) is !(SF^OF). Selector 7 (less) is SF^OF. Selector 8 (less or equal) is (SF^OF) || ZF.
- R4: Unsigned relations are evaluated as follows. Selector 9 (above) is !CF && !ZF. Selector 10 (above or equal) is !CF. Selector 11 (below) is CF. Selector 12 (below or equal) is CF || ZF.
- R5: Selector 0 is true for every combination of flags.
- R6: Selectors 13, 14 and 15 give a false outcome and set bad_cond_o. For every other selector bad_cond_o is 0.
- R7: set_dst_o[7:0] is 8'h01 when the outcome is true and 8'h00 when it is false. set_dst_o[63:8] equals set_dst_i[63:8].
- R8: With mov_size_i=1 (16-bit), a true outcome places mov_src_i[15:0] in the low 16 bits. The upper 48 bits always come from mov_dst_i, and a false outcome returns mov_dst_i unchanged.
- R9: With mov_size_i=2 (32-bit), the low 32 bits come from mov_src_i if the outcome is true and from mov_dst_i if it is false. The upper 32 bits are zero in both cases.
- R10: With mov_size_i=3 (64-bit), the output is mov_src_i if the outcome is true and mov_dst_i if it is false.
- R11: With mov_size_i=0 (byte), bad_size_o is 1 and mov_dst_o equals mov_dst_i, whatever the outcome. For the other widths bad_size_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cond_i | input | 4 | Condition selector |
| cf_i | input | 1 | Carry flag |
| zf_i | input | 1 | Zero flag |
| sf_i | input | 1 | Sign flag |
| of_i | input | 1 | Overflow flag |
| set_dst_i | input | 64 | Prior value of the byte-set destination |
| set_dst_o | output | 64 | Byte-set result |
| mov_size_i | input | 2 | Move width: 0 byte, 1 16-bit, 2 32-bit, 3 64-bit |
| mov_src_i | input | 64 | Conditional-move source |
| mov_dst_i | input | 64 | Prior value of the conditional-move destination |
| mov_dst_o | output | 64 | Conditional-move result |
| cond_true_o | output | 1 | Evaluated outcome |
| bad_cond_o | output | 1 | Selector has no defined condition |
| bad_size_o | output | 1 | Byte-width move refused |

## Verification
The hardest case to provoke is a 32-bit move whose condition is false. Here the only visible effect is that the upper half of the destination is cleared, and that change is seen only when the destination's upper half holds ones. The stimulus therefore crosses every selector with all sixteen flag combinations. For each case it loads the move destination with patterns whose upper bits are set and cycles through all four widths, so every width meets both outcomes. The unused selectors and the byte width appear in the same sweep, each paired with destinations that a faulty write would visibly change.

// File: rtl/cc_sel_pkg.sv
package cc_sel_pkg;
  localparam int COND_W = 4;

  typedef enum logic [COND_W-1:0] {
    CC_ALWAYS = 4'd0,
    CC_EQ     = 4'd1,
    CC_NE     = 4'd2,
    CC_NEG    = 4'd3,
    CC_NNEG   = 4'd4,
    CC_SGT    = 4'd5,
    CC_SGE    = 4'd6,
    CC_SLT    = 4'd7,
    CC_SLE    = 4'd8,
    CC_UGT    = 4'd9,
    CC_UGE    = 4'd10,
    CC_ULT    = 4'd11,
    CC_ULE    = 4'd12
  } cc_code_e;

  typedef enum logic [1:0] {
    MV_B8  = 2'd0,
    MV_B16 = 2'd1,
    MV_B32 = 2'd2,
    MV_B64 = 2'd3
  } mv_size_e;
endpackage

// File: rtl/cc_cond_eval.sv
module cc_cond_eval
  import cc_sel_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  logic              cf_i,
  input  logic              zf_i,
  input  logic              sf_i,
  input  logic              of_i,
  output logic              hit_o,
  output logic              bad_o
);
  logic lt_s;
  assign lt_s = sf_i ^ of_i;

  always_comb begin
    bad_o = 1'b0;
    unique case (cond_i)
      CC_ALWAYS: hit_o = 1'b1;
      CC_EQ:     hit_o = zf_i;
      CC_NE:     hit_o = !zf_i;
      CC_NEG:    hit_o = sf_i;
      CC_NNEG:   hit_o = !sf_i;
      CC_SGT:    hit_o = !lt_s && !zf_i;
      CC_SGE:    hit_o = !lt_s;
      CC_SLT:    hit_o = lt_s;
      CC_SLE:    hit_o = lt_s || zf_i;
      CC_UGT:    hit_o = !cf_i && !zf_i;
      CC_UGE:    hit_o = !cf_i;
      CC_ULT:    hit_o = cf_i;
      CC_ULE:    hit_o = cf_i || zf_i;
      default: begin
        hit_o = 1'b0;
        bad_o = 1'b1;
      end
    endcase
  end

  always_comb begin
    p_bad_is_false_r6: assert (!(bad_o && hit_o));
    p_always_true_r5: assert (cond_i != CC_ALWAYS || hit_o);
  end
endmodule

// File: rtl/cc_set_path.sv
module cc_set_path #(
  parameter int DATA_W = 64
) (
  input  logic              hit_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] dst_o
);
  localparam int BYTE_W = 8;

  assign dst_o = {dst_i[DATA_W-1:BYTE_W], {(BYTE_W-1){1'b0}}, hit_i};

  always_comb begin
    p_upper_kept_r7: assert (dst_o[DATA_W-1:BYTE_W] == dst_i[DATA_W-1:BYTE_W]);
    p_byte_bool_r7: assert (dst_o[BYTE_W-1:0] <= 1);
  end
endmodule

// File: rtl/cc_cmov_path.sv
module cc_cmov_path
  import cc_sel_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              hit_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] dst_o,
  output logic              bad_size_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int QTR_W  = DATA_W / 4;

  logic [DATA_W-1:0] pick;
  assign pick = hit_i ? src_i : dst_i;

  always_comb begin
    bad_size_o = 1'b0;
    unique case (size_i)
      MV_B16:  dst_o = {dst_i[DATA_W-1:QTR_W], pick[QTR_W-1:0]};
      MV_B32:  dst_o = {{HALF_W{1'b0}}, pick[HALF_W-1:0]};
      MV_B64:  dst_o = pick;
      default: begin
        dst_o      = dst_i;
        bad_size_o = 1'b1;
      end
    endcase
  end

  always_comb begin
    p_w32_upper_zero_r9: assert (size_i != MV_B32 || dst_o[DATA_W-1:HALF_W] == '0);
    p_byte_refused_r11: assert (size_i != MV_B8 || dst_o == dst_i);
    p_w16_upper_kept_r8: assert (size_i != MV_B16 || dst_o[DATA_W-1:QTR_W] == dst_i[DATA_W-1:QTR_W]);
    p_w64_choice_r10: assert (size_i != MV_B64 || dst_o == src_i || dst_o == dst_i);
  end
endmodule

// File: rtl/cc_select_unit.sv
module cc_select_unit
  import cc_sel_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [COND_W-1:0] cond_i,
  input  logic              cf_i,
  input  logic              zf_i,
  input  logic              sf_i,
  input  logic              of_i,
  input  logic [DATA_W-1:0] set_dst_i,
  output logic [DATA_W-1:0] set_dst_o,
  input  logic [1:0]        mov_size_i,
  input  logic [DATA_W-1:0] mov_src_i,
  input  logic [DATA_W-1:0] mov_dst_i,
  output logic [DATA_W-1:0] mov_dst_o,
  output logic              cond_true_o,
  output logic              bad_cond_o,
  output logic              bad_size_o
);
  logic hit;

  cc_cond_eval u_eval (
    .cond_i (cond_i),
    .cf_i   (cf_i),
    .zf_i   (zf_i),
    .sf_i   (sf_i),
    .of_i   (of_i),
    .hit_o  (hit),
    .bad_o  (bad_cond_o)
  );

  cc_set_path #(.DATA_W(DATA_W)) u_set (
    .hit_i (hit),
    .dst_i (set_dst_i),
    .dst_o (set_dst_o)
  );

  cc_cmov_path #(.DATA_W(DATA_W)) u_cmov (
    .hit_i      (hit),
    .size_i     (mov_size_i),
    .src_i      (mov_src_i),
    .dst_i      (mov_dst_i),
    .dst_o      (mov_dst_o),
    .bad_size_o (bad_size_o)
  );

  assign cond_true_o = hit;

  always_comb begin
    p_set_tracks_outcome_r7: assert (set_dst_o[0] == cond_true_o);
    p_unused_code_r6: assert (!(bad_cond_o && cond_true_o));
  end
endmodule

// File: tb/cc_select_unit_tb.sv
module cc_select_unit_tb;
  localparam int CLK_P = 10;
  localparam int WDOG  = 20000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [3:0]  cond_i = '0;
  logic        cf_i = 0, zf_i = 0, sf_i = 0, of_i = 0;
  logic [63:0] set_dst_i = '0, mov_src_i = '0, mov_dst_i = '0;
  logic [1:0]  mov_size_i = '0;
  logic [63:0] set_dst_o, mov_dst_o;
  logic        cond_true_o, bad_cond_o, bad_size_o;

  cc_select_unit u_dut (
    .cond_i(cond_i), .cf_i(cf_i), .zf_i(zf_i), .sf_i(sf_i), .of_i(of_i),
    .set_dst_i(set_dst_i), .set_dst_o(set_dst_o), .mov_size_i(mov_size_i),
    .mov_src_i(mov_src_i), .mov_dst_i(mov_dst_i), .mov_dst_o(mov_dst_o),
    .cond_true_o(cond_true_o), .bad_cond_o(bad_cond_o), .bad_size_o(bad_size_o)
  );

  typedef struct {
    logic        t;
    logic        bc;
    logic        bs;
    logic [63:0] so;
    logic [63:0] mo;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  function automatic logic ref_cond(input logic [3:0] c, input logic cf, zf, sf, of);
    logic l;
    l = sf ^ of;
    case (c)
      4'd0:  return 1'b1;
      4'd1:  return zf;
      4'd2:  return !zf;
      4'd3:  return sf;
      4'd4:  return !sf;
      4'd5:  return !l && !zf;
      4'd6:  return !l;
      4'd7:  return l;
      4'd8:  return l || zf;
      4'd9:  return !cf && !zf;
      4'd10: return !cf;
      4'd11: return cf;
      4'd12: return cf || zf;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string cond_tag(input logic [3:0] c);
    if (c == 0) return "R5";
    if (c <= 2) return "R1";
    if (c <= 4) return "R2";
    if (c <= 8) return "R3";
    if (c <= 12) return "R4";
    return "R6";
  endfunction

  function automatic string size_tag(input logic [1:0] s);
    case (s)
      2'd0: return "R11";
      2'd1: return "R8";
      2'd2: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic drive(input logic [3:0] c, input logic [3:0] fl, input logic [1:0] sz,
                       input logic [63:0] sd, input logic [63:0] ms, input logic [63:0] md);
    exp_t e;
    logic t;
    @(posedge clk);
    cond_i = c; cf_i = fl[0]; zf_i = fl[1]; sf_i = fl[2]; of_i = fl[3];
    mov_size_i = sz; set_dst_i = sd; mov_src_i = ms; mov_dst_i = md;
    t = ref_cond(c, fl[0], fl[1], fl[2], fl[3]);
    e.t  = t;
    e.bc = (c > 4'd12);
    e.bs = (sz == 2'd0);
    e.so = {sd[63:8], 7'd0, t};   // R7
    case (sz)
      2'd0: e.mo = md;
      2'd1: e.mo = {md[63:16], t ? ms[15:0] : md[15:0]};
      2'd2: e.mo = {32'd0, t ? ms[31:0] : md[31:0]};
      default: e.mo = t ? ms : md;
    endcase
    e.tag = {cond_tag(c), " R7 ", size_tag(sz)};
    sb_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      total++;
      if (cond_true_o !== e.t || bad_cond_o !== e.bc || bad_size_o !== e.bs ||
          set_dst_o !== e.so || mov_dst_o !== e.mo) begin
        bad++;
        $display("FAIL %s cond=%0d act t=%b bc=%b bs=%b set=%h mov=%h exp t=%b bc=%b bs=%b set=%h mov=%h",
                 e.tag, cond_i, cond_true_o, bad_cond_o, bad_size_o, set_dst_o, mov_dst_o,
                 e.t, e.bc, e.bs, e.so, e.mo);
      end
    end
  end

  initial begin
    for (int n = 0; n < WDOG; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // quiet inputs: selector 0 true, byte move refused
    drive(4'd0, 4'd0, 2'd0, 64'h0, 64'h0, 64'h0);
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        drive(4'(c), 4'(f), 2'(f + c),
              {$urandom, $urandom} | 64'hFF00_0000_0000_FF00,
              {$urandom, $urandom},
              {$urandom, $urandom} | 64'hFFFF_FFFF_0000_0000);
      end
    end
    // R9: false 32-bit move still clears upper half
    drive(4'd1, 4'b0000, 2'd2, 64'h0, 64'h1111_2222_3333_4444, 64'hFFFF_FFFF_FFFF_FFFF);
    // R11: true byte-width move leaves destination alone
    drive(4'd0, 4'b0000, 2'd0, 64'h0, 64'h0123_4567_89AB_CDEF, 64'hDEAD_BEEF_CAFE_F00D);
    // R8: true 16-bit move keeps upper 48 bits
    drive(4'd11, 4'b0001, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hAAAA_BBBB_CCCC_1234, 64'h5555_6666_7777_8888);
    // R6: unused code ignores flags
    drive(4'd15, 4'b1111, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h2);
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule